// File: doc/BRIEF.md
# Audio Frame Sequencer

This block produces the slow timing strobes of a console sound generator. A down-counting divider runs once per CPU clock. Each time it expires, a step counter moves on by one, and the block decodes the current step into a quarter-frame enable and a half-frame enable. Envelope and linear-counter logic downstream use the quarter-frame enable. Length and sweep logic use the half-frame enable. Both enables are one CPU cycle wide.

Two step patterns are available. The four-step pattern can raise a frame interrupt flag on its last step. The five-step pattern skips one quarter strobe and never interrupts. Software picks the pattern with a control write. That write also restarts the sequence. Reading the status register acknowledges the interrupt. The block has no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `frame_seq`

## Requirements
- R1: While reset is held, both enables and the interrupt flag are low. The block comes out of reset in four-step mode at step 0, with inhibit clear and the divider at RELOAD, so the first quarter enable appears RELOAD+1 cycles after release.
- R2: Two consecutive divider expiries with no control write between them are exactly RELOAD+1 cycles apart.
- R3: In four-step mode, steps 0 to 3 each give a quarter enable. Steps 1 and 3 also give a half enable. The step count then wraps from 3 back to 0.
- R4: In four-step mode, the expiry at step 3 sets the interrupt flag when inhibit is 0. The flag stays set until a clear condition occurs.
- R5: In five-step mode, steps 0, 1, 2 and 4 give a quarter enable and step 3 gives none. Steps 1 and 4 give a half enable. The step count wraps from 4 back to 0. The interrupt flag is never set in this mode.
- R6: A control write (ctrl_wr high) sets the step count to 0 and loads the divider with RELOAD+EXTRA. The next expiry, which is at step 0, therefore shows its quarter enable RELOAD+EXTRA+1 cycles after the enable cycle that follows the write.
- R7: On a control write, ctrl_data bit 7 selects the mode: 1 is five-step, 0 is four-step. When bit 7 is 1, a quarter enable and a half enable appear together in the cycle after the write. When bit 7 is 0, neither appears. A divider expiry in the same cycle as a write is dropped, so no enable fires twice.
- R8: On a control write, ctrl_data bit 6 sets inhibit. A write with bit 6 set clears the interrupt flag in the next cycle. While inhibit is 1, step 3 does not set the flag.
- R9: stat_rd clears the interrupt flag in the next cycle. If the flag is set in the same cycle, the set wins and the flag stays high.
- R10: Each enable is high for one cycle only, and a half enable always comes with a quarter enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control write data: bit 7 selects five-step mode, bit 6 sets inhibit |
| stat_rd | input | 1 | Status read strobe; acknowledges the interrupt |
| qtr_pulse | output | 1 | Quarter-frame enable, one cycle wide |
| half_pulse | output | 1 | Half-frame enable, one cycle wide |
| irq_flag | output | 1 | Frame interrupt flag |

## Verification
Two cases are hard to reach from the ports. The first is a control write that lands in the same cycle the divider expires. The second is a status read that lands in the same cycle step 3 sets the flag. With the full-size divider, each case needs precise placement inside a window of several thousand cycles. The bench therefore builds the block with a tiny reload value. It then sweeps the gap between a restarting control write and a following write or status read over every offset across several sequence periods, so that every phase of the divider and the step counter meets every input event.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef logic [2:0] step_t;

  // quarter enable for a given mode and step
  function automatic logic qtr_for(input logic five, input step_t s);
    if (five) return (s != 3'd3);
    return 1'b1;
  endfunction

  // half enable for a given mode and step
  function automatic logic half_for(input logic five, input step_t s);
    if (five) return (s == 3'd1) || (s == 3'd4);
    return (s == 3'd1) || (s == 3'd3);
  endfunction

  function automatic step_t step_after(input logic five, input step_t s);
    step_t last;
    last = five ? 3'd4 : 3'd3;
    return (s == last) ? 3'd0 : s + 3'd1;
  endfunction

endpackage

// File: rtl/fseq_divider.sv
module fseq_divider #(
  parameter int RELOAD = 7456,
  parameter int EXTRA  = 8,
  parameter int W      = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_wr,
  output logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] BASE  = W'(RELOAD);
  localparam logic [W-1:0] START = W'(RELOAD + EXTRA);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= BASE;
    else if (load_wr)      cnt_q <= START;
    else if (cnt_q == '0)  cnt_q <= BASE;
    else                   cnt_q <= cnt_q - W'(1);
  end

  assign tick  = (cnt_q == '0) && !load_wr;
  assign count = cnt_q;
endmodule

// File: rtl/fseq_stepper.sv
module fseq_stepper
  import fseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wr,
  input  logic wr_five,
  output logic qtr,
  output logic half,
  output logic five,
  output logic set_req
);
  step_t step_q;
  logic  five_q, qtr_q, half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      five_q <= 1'b0;
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (wr) begin
      step_q <= '0;
      five_q <= wr_five;
      qtr_q  <= wr_five;
      half_q <= wr_five;
    end else if (tick) begin
      step_q <= step_after(five_q, step_q);
      qtr_q  <= qtr_for(five_q, step_q);
      half_q <= half_for(five_q, step_q);
    end else begin
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end
  end

  assign qtr     = qtr_q;
  assign half    = half_q;
  assign five    = five_q;
  assign set_req = tick && !five_q && (step_q == 3'd3);
endmodule

// File: rtl/fseq_irq.sv
module fseq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_inh,
  input  logic rd,
  input  logic set_req,
  output logic inhibit,
  output logic flag
);
  logic inh_q, flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inh_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr) inh_q <= wr_inh;
      if (set_req && !inh_q)          flag_q <= 1'b1;
      else if ((wr && wr_inh) || rd)  flag_q <= 1'b0;
    end
  end

  assign inhibit = inh_q;
  assign flag    = flag_q;
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int RELOAD = 7456,
  parameter int EXTRA  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_data,
  input  logic       stat_rd,
  output logic       qtr_pulse,
  output logic       half_pulse,
  output logic       irq_flag
);
  localparam int DIV_W = $clog2(RELOAD + EXTRA + 1);
  localparam int MODE_BIT = 7;
  localparam int INH_BIT  = 6;

  logic             tick;
  logic [DIV_W-1:0] div_count;
  logic             mode_five;
  logic             inhibit;
  logic             set_req;

  fseq_divider #(.RELOAD(RELOAD), .EXTRA(EXTRA), .W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load_wr(ctrl_wr), .tick(tick), .count(div_count)
  );

  fseq_stepper u_step (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(ctrl_wr),
    .wr_five(ctrl_data[MODE_BIT]), .qtr(qtr_pulse), .half(half_pulse),
    .five(mode_five), .set_req(set_req)
  );

  fseq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wr_inh(ctrl_data[INH_BIT]),
    .rd(stat_rd), .set_req(set_req), .inhibit(inhibit), .flag(irq_flag)
  );
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int RELOAD = 7456,
  parameter int EXTRA  = 8,
  parameter int W      = 13
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctrl_wr,
  input logic [7:0]   ctrl_data,
  input logic         stat_rd,
  input logic         qtr_pulse,
  input logic         half_pulse,
  input logic         irq_flag,
  input logic         mode_five,
  input logic         inhibit,
  input logic         set_req,
  input logic [W-1:0] div_count
);
  // R10
  half_with_qtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_pulse |-> qtr_pulse);

  // R7
  wr_five_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_data[7]) |=> (qtr_pulse && half_pulse));

  // R7
  wr_four_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_data[7]) |=> (!qtr_pulse && !half_pulse));

  // R6
  wr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (div_count == W'(RELOAD + EXTRA)));

  // R8
  inh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_data[6]) |=> !irq_flag);

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !set_req) |=> !irq_flag);

  // R5
  five_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> (!mode_five && !inhibit));
endmodule

bind frame_seq fseq_chk #(.RELOAD(RELOAD), .EXTRA(EXTRA), .W(DIV_W)) u_fseq_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
  .stat_rd(stat_rd), .qtr_pulse(qtr_pulse), .half_pulse(half_pulse),
  .irq_flag(irq_flag), .mode_five(mode_five), .inhibit(inhibit),
  .set_req(set_req), .div_count(div_count)
);

// File: tb/test_frame_seq.sv
module test_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam int R = 6;
  localparam int X = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_data = 8'h00;
  logic       stat_rd = 1'b0;
  logic       qtr_pulse, half_pulse, irq_flag;

  frame_seq #(.RELOAD(R), .EXTRA(X)) i_frame_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .stat_rd(stat_rd), .qtr_pulse(qtr_pulse), .half_pulse(half_pulse),
    .irq_flag(irq_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int m_div, m_step;
  bit m_five, m_inh, m_irq, e_q, e_h;
  bit prev_wr, prev_rd;
  int cyc = 0;
  int w_cyc = -100;
  bit r6_done = 1;
  int prev_q = -1000;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_div = R; m_step = 0; m_five = 0; m_inh = 0; m_irq = 0; e_q = 0; e_h = 0;
  endtask

  task automatic model_next(input bit wr, input bit [7:0] d, input bit rd);
    bit setf;
    setf = 0;
    if (wr) begin
      m_five = d[7]; m_inh = d[6]; m_step = 0; m_div = R + X;
      e_q = d[7]; e_h = d[7];
    end else if (m_div == 0) begin
      m_div = R;
      if (m_five) begin
        e_q = (m_step != 3); e_h = (m_step == 1) || (m_step == 4);
        m_step = (m_step + 1) % 5;
      end else begin
        e_q = 1; e_h = (m_step == 1) || (m_step == 3);
        setf = (m_step == 3) && !m_inh;
        m_step = (m_step + 1) % 4;
      end
    end else begin
      m_div = m_div - 1; e_q = 0; e_h = 0;
    end
    if (setf) m_irq = 1;
    else if ((wr && d[6]) || rd) m_irq = 0;
  endtask

  task automatic compare();
    string tq, ti;
    cyc++;
    tq = prev_wr ? "R7" : (m_five ? "R5" : "R3");
    ti = prev_rd ? "R9" : (prev_wr ? "R8" : (m_five ? "R5" : "R4"));
    check(qtr_pulse == e_q, tq, "qtr_pulse", qtr_pulse, e_q);
    check(half_pulse == e_h, (half_pulse && !qtr_pulse) ? "R10" : tq, "half_pulse", half_pulse, e_h);
    check(irq_flag == m_irq, ti, "irq_flag", irq_flag, m_irq);
    if (qtr_pulse && cyc > w_cyc + 1) begin
      if (!r6_done) begin
        check(cyc == w_cyc + R + X + 2, "R6", "first expiry cycle after write", cyc, w_cyc + R + X + 2);
        r6_done = 1;
      end else if (!m_five && prev_q >= w_cyc + R + X + 2) begin
        check(cyc - prev_q == R + 1, "R2", "expiry spacing", cyc - prev_q, R + 1);
      end
      prev_q = cyc;
    end
  endtask

  task automatic tick(input bit wr, input bit [7:0] d, input bit rd);
    ctrl_wr = wr; ctrl_data = d; stat_rd = rd;
    if (wr) begin w_cyc = cyc; r6_done = 0; end
    model_next(wr, d, rd);
    prev_wr = wr; prev_rd = rd;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 8'h00, 0);
  endtask

  initial begin
    int first_q;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(qtr_pulse == 0 && half_pulse == 0, "R1", "enables in reset", {qtr_pulse, half_pulse}, 0);
    check(irq_flag == 0, "R1", "flag in reset", irq_flag, 0);
    rst_n = 1'b1;
    prev_wr = 0; prev_rd = 0;
    first_q = -1;
    for (int i = 0; i < R + 3; i++) begin
      tick(0, 8'h00, 0);
      if (qtr_pulse && first_q < 0) first_q = cyc;
    end
    check(first_q == R + 1, "R1", "first quarter after release", first_q, R + 1);
    w_cyc = 0;
    idle(40);
    tick(0, 8'h00, 1);
    idle(5);
    tick(1, 8'h80, 0);
    idle(50);
    tick(0, 8'h00, 1);
    tick(1, 8'h00, 0);
    idle(30);
    tick(1, 8'h40, 0);
    idle(40);
    tick(1, 8'hC0, 0);
    idle(40);
    // sweep status read against every phase
    for (int off = 0; off < 4 * (R + 1) + X + 2; off++) begin
      tick(1, 8'h00, 0);
      idle(off);
      tick(0, 8'h00, 1);
      idle(2);
    end
    // sweep control writes against every phase, both modes
    for (int off = 0; off < 5 * (R + 1) + X + 2; off++) begin
      tick(1, (off % 2) ? 8'h80 : 8'h00, 0);
      idle(off);
      tick(1, (off % 3 == 0) ? 8'h80 : ((off % 3 == 1) ? 8'h40 : 8'h00), 0);
      idle(R + X + 4);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule